// File: doc/BRIEF.md
# Wavetable Carrier Oscillator

This block is the carrier voice of a wavetable sound generator. It keeps a 64-entry table of 6-bit waveform samples. A phase accumulator walks through that table, and each chosen sample is scaled by an envelope volume and by a selectable master-volume divisor to give an unsigned output sample. The host writes the table and three control registers through a small register port.

The per-clock phase step is the carrier frequency times 64. An external modulator can shift the step by a signed offset, and the step is clamped so that it never runs backwards. The host reloads the table while the carrier is frozen in write mode, and it can stop and rewind the carrier through the disable bit.

Top module: `wavetable_carrier`

## Requirements
- R1: While and after reset, before any write: phase is 0, frequency is 0, the carrier is disabled, write mode is off, the divisor select is 0, `sampleOut` is 0 and every table entry is 0.
- R2: Register map. An address with bit 6 clear selects table entry `regAddr[5:0]`. 0x40 is frequency bits [7:0]. 0x41 holds frequency bits [11:8] in data bits [3:0] and the disable flag in data bit 7. 0x42 holds write mode in bit 7 and the divisor select in bits [1:0]. With modulation off, an advancing carrier adds frequency × 64 to a 27-bit phase on every clock.
- R3: While `modEnable` is 1, the step becomes frequency × 64 + frequency × `modValue` (signed), and a negative step is replaced by 0. While `modEnable` is 0, `modValue` has no effect.
- R4: The table entry being played is selected by phase bits [26:21].
- R5: The phase does not move on any clock where write mode or the disable flag is set.
- R6: A write to 0x41 with data bit 7 set returns the phase to 0 on that clock.
- R7: A table write stores data bits [5:0], and only while write mode is set. Otherwise the write is ignored.
- R8: `regRdata[7:6]` always equals `busTop`. For a table address, bits [5:0] give the addressed entry in write mode, and the entry being played otherwise, whatever the address. For control addresses, bits [5:0] read 0.
- R9: A new sample equals floor(entry × min(volume, 32) × 4 / (divisor select + 2)) for every reachable input.
- R10: `sampleOut` is recomputed only on a clock where the advancing phase changes bit 21. It uses the newly indexed entry and the current volume and divisor, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 7 | Register / table address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data (combinational) |
| busTop | input | 2 | Upper read bits, passed through from the host bus |
| modEnable | input | 1 | Applies the modulation offset to the step |
| modValue | input | 8 | Signed modulation value |
| volume | input | 6 | Envelope volume, capped at 32 internally |
| sampleOut | output | 12 | Unsigned output sample |

## Verification
A wrong phase cannot be seen directly. It shows up outside write mode through the table read, which returns the entry being played, so a step, clamp or freeze error appears as a wrong entry within one index period: 16 clocks at frequency 0x800. A wrong divisor constant or a wrong volume cap changes `sampleOut` at the next index change. A missed recompute or a spurious one shows as a sample that tracks the volume input while the carrier is stopped. A table loaded with a ramp makes each index error visible as a distinct value.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
  localparam int REG_ADDR_W = 7;
  localparam logic [REG_ADDR_W-1:0] ADDR_FREQ_LO = 7'h40;
  localparam logic [REG_ADDR_W-1:0] ADDR_FREQ_HI = 7'h41;
  localparam logic [REG_ADDR_W-1:0] ADDR_MASTER  = 7'h42;

  typedef struct packed {
    logic waveWe;
    logic phaseClear;
    logic advance;
  } ctrlStrobes_t;

  function automatic int unsigned recipCeil(int unsigned d, int unsigned shift);
    return ((32'd1 << shift) + d - 1) / d;
  endfunction
endpackage

// File: rtl/wtc_ctrl.sv
`timescale 1ns/1ps
module wtc_ctrl import wtc_pkg::*; #(
  parameter int FREQ_W = 12,
  parameter int DIV_W  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [7:0]            regWdata,
  output ctrlStrobes_t          strobes,
  output logic [FREQ_W-1:0]     freq,
  output logic                  writeMode,
  output logic                  disabled,
  output logic [DIV_W-1:0]      divSel
);
  localparam int HI_BITS = FREQ_W - 8;

  logic hitLo, hitHi, hitMaster, isWave;

  always_comb begin
    isWave    = !regAddr[REG_ADDR_W-1];
    hitLo     = regWe && (regAddr == ADDR_FREQ_LO);
    hitHi     = regWe && (regAddr == ADDR_FREQ_HI);
    hitMaster = regWe && (regAddr == ADDR_MASTER);
    strobes.waveWe     = regWe && isWave && writeMode;
    strobes.phaseClear = hitHi && regWdata[7];
    strobes.advance    = !writeMode && !disabled;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freq      <= '0;
      writeMode <= 1'b0;
      disabled  <= 1'b1;
      divSel    <= '0;
    end else begin
      if (hitLo) freq[7:0] <= regWdata;
      if (hitHi) begin
        freq[FREQ_W-1:8] <= regWdata[HI_BITS-1:0];
        disabled         <= regWdata[7];
      end
      if (hitMaster) begin
        writeMode <= regWdata[7];
        divSel    <= regWdata[DIV_W-1:0];
      end
    end
  end
endmodule

// File: rtl/wtc_datapath.sv
`timescale 1ns/1ps
module wtc_datapath import wtc_pkg::*; #(
  parameter int PHASE_W    = 27,
  parameter int FREQ_W     = 12,
  parameter int MOD_W      = 8,
  parameter int WAVE_W     = 6,
  parameter int IDX_W      = 6,
  parameter int VOL_W      = 6,
  parameter int VOL_CAP    = 32,
  parameter int DIV_W      = 2,
  parameter int OUT_W      = 12,
  parameter int BASE_SHIFT = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strobes,
  input  logic [IDX_W-1:0]        waveIdx,
  input  logic [WAVE_W-1:0]       waveData,
  input  logic [IDX_W-1:0]        rdIdx,
  input  logic [FREQ_W-1:0]       freq,
  input  logic                    modEnable,
  input  logic signed [MOD_W-1:0] modValue,
  input  logic [VOL_W-1:0]        volume,
  input  logic [DIV_W-1:0]        divSel,
  output logic [WAVE_W-1:0]       rdWave,
  output logic [IDX_W-1:0]        playIdx,
  output logic [PHASE_W-1:0]      phaseNow,
  output logic [OUT_W-1:0]        sampleOut
);
  localparam int DEPTH       = 1 << IDX_W;
  localparam int IDX_LSB     = PHASE_W - IDX_W;
  localparam int STEP_W      = FREQ_W + MOD_W + 2;
  localparam int RECIP_SHIFT = 16;
  localparam int RECIP_W     = RECIP_SHIFT + 1;
  localparam int PROD_W      = WAVE_W + VOL_W + 2;
  localparam int SCALED_W    = PROD_W + RECIP_W;
  localparam int DIV_CNT     = 1 << DIV_W;

  logic [WAVE_W-1:0]        waveMem [DEPTH];
  logic [PHASE_W-1:0]       phaseQ, phaseNext;
  logic signed [STEP_W-1:0] freqS, modS, baseStep, modStep, rawStep;
  logic [STEP_W-1:0]        step;
  logic [IDX_W-1:0]         idxNext;
  logic                     bitFlip;
  logic [VOL_W-1:0]         volCap;
  logic [PROD_W-1:0]        product;
  logic [SCALED_W-1:0]      scaled;
  logic [RECIP_W-1:0]       recipTab [DIV_CNT];
  logic [OUT_W-1:0]         sampleQ;

  for (genvar g = 0; g < DIV_CNT; g++) begin : g_recip
    assign recipTab[g] = RECIP_W'(recipCeil(g + 2, RECIP_SHIFT));
  end

  always_comb begin
    freqS    = $signed(STEP_W'(freq));
    modS     = $signed({{(STEP_W-MOD_W){modValue[MOD_W-1]}}, modValue});
    baseStep = $signed(STEP_W'({freq, {BASE_SHIFT{1'b0}}}));
    modStep  = modEnable ? freqS * modS : '0;
    rawStep  = baseStep + modStep;
    step     = rawStep[STEP_W-1] ? '0 : STEP_W'(rawStep);
    phaseNext = phaseQ + PHASE_W'(step);
    idxNext   = phaseNext[IDX_LSB +: IDX_W];
    bitFlip   = strobes.advance && !strobes.phaseClear
                && (phaseNext[IDX_LSB] != phaseQ[IDX_LSB]);
    volCap  = (volume > VOL_W'(VOL_CAP)) ? VOL_W'(VOL_CAP) : volume;
    product = (PROD_W'(waveMem[idxNext]) * PROD_W'(volCap)) << 2;
    scaled  = SCALED_W'(product) * SCALED_W'(recipTab[divSel]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= '0;
      sampleQ <= '0;
    end else begin
      if (strobes.phaseClear)   phaseQ <= '0;
      else if (strobes.advance) phaseQ <= phaseNext;
      if (bitFlip) sampleQ <= scaled[RECIP_SHIFT +: OUT_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) waveMem[i] <= '0;
    end else if (strobes.waveWe) begin
      waveMem[waveIdx] <= waveData;
    end
  end

  assign rdWave    = waveMem[rdIdx];
  assign playIdx   = phaseQ[IDX_LSB +: IDX_W];
  assign phaseNow  = phaseQ;
  assign sampleOut = sampleQ;
endmodule

// File: rtl/wavetable_carrier.sv
`timescale 1ns/1ps
module wavetable_carrier import wtc_pkg::*; #(
  parameter int PHASE_W = 27,
  parameter int FREQ_W  = 12,
  parameter int MOD_W   = 8,
  parameter int WAVE_W  = 6,
  parameter int IDX_W   = 6,
  parameter int VOL_W   = 6,
  parameter int VOL_CAP = 32,
  parameter int DIV_W   = 2,
  parameter int OUT_W   = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [REG_ADDR_W-1:0]   regAddr,
  input  logic [7:0]              regWdata,
  output logic [7:0]              regRdata,
  input  logic [7-WAVE_W:0]       busTop,
  input  logic                    modEnable,
  input  logic signed [MOD_W-1:0] modValue,
  input  logic [VOL_W-1:0]        volume,
  output logic [OUT_W-1:0]        sampleOut
);
  localparam int MAX_SAMPLE = ((1 << WAVE_W) - 1) * VOL_CAP * 4 / 2;

  ctrlStrobes_t       strobes;
  logic [FREQ_W-1:0]  freq;
  logic               writeMode, disabled;
  logic [DIV_W-1:0]   divSel;
  logic [IDX_W-1:0]   playIdx, rdIdx;
  logic [WAVE_W-1:0]  rdWave;
  logic [PHASE_W-1:0] phaseNow;

  wtc_ctrl #(.FREQ_W(FREQ_W), .DIV_W(DIV_W)) u_ctrl (
    .clk, .rstN, .regWe, .regAddr, .regWdata,
    .strobes, .freq, .writeMode, .disabled, .divSel
  );

  assign rdIdx = writeMode ? regAddr[IDX_W-1:0] : playIdx;

  wtc_datapath #(
    .PHASE_W(PHASE_W), .FREQ_W(FREQ_W), .MOD_W(MOD_W), .WAVE_W(WAVE_W),
    .IDX_W(IDX_W), .VOL_W(VOL_W), .VOL_CAP(VOL_CAP), .DIV_W(DIV_W), .OUT_W(OUT_W)
  ) u_dp (
    .clk, .rstN, .strobes,
    .waveIdx(regAddr[IDX_W-1:0]), .waveData(regWdata[WAVE_W-1:0]), .rdIdx,
    .freq, .modEnable, .modValue, .volume, .divSel,
    .rdWave, .playIdx, .phaseNow, .sampleOut
  );

  assign regRdata = regAddr[REG_ADDR_W-1] ? {busTop, WAVE_W'(0)} : {busTop, rdWave};
endmodule

// File: rtl/wtc_checker.sv
`timescale 1ns/1ps
module wtc_checker #(
  parameter int PHASE_W = 27,
  parameter int IDX_LSB = 21,
  parameter int OUT_W   = 12,
  parameter int MAX_OUT = 4032
) (
  input logic               clk,
  input logic               rstN,
  input logic [PHASE_W-1:0] phaseNow,
  input logic [OUT_W-1:0]   sampleOut,
  input logic               waveWe,
  input logic               writeMode,
  input logic               disabled,
  input logic               phaseClear
);
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((writeMode || disabled) && !phaseClear) |=> $stable(phaseNow));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    phaseClear |=> (phaseNow == '0));

  p_wave_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    waveWe |-> writeMode);

  p_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    sampleOut <= OUT_W'(MAX_OUT));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (phaseNow[IDX_LSB] == $past(phaseNow[IDX_LSB])) |-> $stable(sampleOut));
endmodule

bind wavetable_carrier wtc_checker #(
  .PHASE_W(PHASE_W), .IDX_LSB(PHASE_W - IDX_W), .OUT_W(OUT_W), .MAX_OUT(MAX_SAMPLE)
) u_chk (
  .clk(clk), .rstN(rstN), .phaseNow(phaseNow), .sampleOut(sampleOut),
  .waveWe(strobes.waveWe), .writeMode(writeMode), .disabled(disabled),
  .phaseClear(strobes.phaseClear)
);

// File: tb/sim_wavetable_carrier.sv
`timescale 1ns/1ps
module sim_wavetable_carrier;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWe = 1'b0;
  logic [6:0]        regAddr = '0;
  logic [7:0]        regWdata = '0;
  logic [7:0]        regRdata;
  logic [1:0]        busTop = 2'b10;
  logic              modEnable = 1'b0;
  logic signed [7:0] modValue = '0;
  logic [5:0]        volume = '0;
  logic [11:0]       sampleOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wavetable_carrier u0 (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .regRdata, .busTop,
    .modEnable, .modValue, .volume, .sampleOut
  );

  // {wave, volume, divisor select, expected sample}
  localparam logic [39:0] VEC [8] = '{
    {8'd63, 8'd32, 8'd0, 16'd4032},
    {8'd63, 8'd40, 8'd1, 16'd2688},
    {8'd1,  8'd1,  8'd3, 16'd0},
    {8'd21, 8'd17, 8'd1, 16'd476},
    {8'd50, 8'd33, 8'd3, 16'd1280},
    {8'd7,  8'd5,  8'd2, 16'd35},
    {8'd63, 8'd31, 8'd3, 16'd1562},
    {8'd5,  8'd9,  8'd1, 16'd60}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [6:0] a, input logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readAt(input logic [6:0] a, output int v);
    regAddr = a;
    #1 v = int'(regRdata);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(1);

    // R1: reset state
    check("R1 sampleOut", int'(sampleOut), 0);
    readAt(7'h05, v);
    check("R1 table read", v, 8'h80);

    // R9 table walk, carrier at freq 0x800 (R2 map)
    regWrite(7'h40, 8'h00);
    regWrite(7'h41, 8'h08);
    foreach (VEC[k]) begin
      regWrite(7'h42, 8'h80);
      for (int i = 0; i < 64; i++) regWrite(7'(i), VEC[k][39:32]);
      volume = VEC[k][29:24];
      regWrite(7'h42, VEC[k][23:16]);
      waitEdges(40);
      check($sformatf("R9 vector %0d", k), int'(sampleOut), int'(VEC[k][15:0]));
    end

    // Ramp table: entry i = i + 5
    regWrite(7'h42, 8'h80);
    for (int i = 0; i < 64; i++) regWrite(7'(i), 8'((i + 5) & 63));
    readAt(7'h09, v);
    check("R8 write-mode addressed read", v, 8'h80 | 14);
    volume = 6'd10;
    regWrite(7'h41, 8'h88);
    regWrite(7'h42, 8'h00);
    regWrite(7'h41, 8'h08);
    waitEdges(40);
    readAt(7'h11, v);
    check("R4 R2 playing entry at 40 clocks", v, 8'h80 | 7);
    check("R10 sample at index 2", int'(sampleOut), 140);

    // R5: frozen in write mode
    regWrite(7'h42, 8'h80);
    waitEdges(60);
    check("R10 held while frozen", int'(sampleOut), 140);
    regWrite(7'h42, 8'h00);
    waitEdges(10);
    readAt(7'h11, v);
    check("R5 phase frozen in write mode", v, 8'h80 | 8);

    // R6: disable rewinds phase; R10 hold
    regWrite(7'h41, 8'h88);
    waitEdges(30);
    readAt(7'h02, v);
    check("R6 phase reset to 0", v, 8'h80 | 5);
    volume = 6'd20;
    waitEdges(10);
    check("R10 no recompute on volume change", int'(sampleOut), 160);
    volume = 6'd10;

    // R3: positive modulation
    modValue = 8'sd64; modEnable = 1'b1;
    regWrite(7'h41, 8'h08);
    waitEdges(20);
    readAt(7'h02, v);
    check("R3 modulated step", v, 8'h80 | 7);
    regWrite(7'h41, 8'h88);
    modEnable = 1'b0;
    regWrite(7'h41, 8'h08);
    waitEdges(20);
    readAt(7'h02, v);
    check("R3 modValue ignored when disabled", v, 8'h80 | 6);

    // R3: negative step clamps to 0
    regWrite(7'h41, 8'h88);
    modValue = -8'sd100; modEnable = 1'b1;
    regWrite(7'h41, 8'h08);
    waitEdges(40);
    readAt(7'h02, v);
    check("R3 negative step clamped", v, 8'h80 | 5);
    modEnable = 1'b0; modValue = '0;
    regWrite(7'h41, 8'h88);

    // R7: table write ignored outside write mode; 6-bit storage
    regWrite(7'h00, 8'h3F);
    regWrite(7'h42, 8'h80);
    readAt(7'h00, v);
    check("R7 write ignored outside write mode", v, 8'h80 | 5);
    regWrite(7'h01, 8'hFF);
    readAt(7'h01, v);
    check("R7 six-bit store", v, 8'hBF);

    // R8: control address and bus top bits
    readAt(7'h42, v);
    check("R8 control read", v, 8'h80);
    busTop = 2'b01;
    readAt(7'h03, v);
    check("R8 bus top bits", v, 8'h40 | 8);

    // R6: high nibble sets freq[11:8]; 0x400 gives index 1 after 40 clocks
    regWrite(7'h42, 8'h00);
    regWrite(7'h41, 8'h84);
    regWrite(7'h41, 8'h04);
    waitEdges(40);
    readAt(7'h02, v);
    check("R6 frequency high nibble", v, 8'h40 | 63);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule